// File: doc/BRIEF.md
# Compressed Differential Write Unit for Non-Volatile Memory

This block sits in the write path of a memory controller, in front of a non-volatile memory array whose cells wear out and cost energy each time they are programmed. Each write request carries an address and a 32-bit word. The unit first tries to shrink the word with an eight-entry frequent-value dictionary. A word that matches an entry becomes a short prefix code. A word that matches no entry is kept at full width.

The unit then reads the word and its metadata that are already stored at that address. It builds the new bit image, compares it with the old one, and drives a per-bit write mask, so that only cells whose value really changes are programmed. A compressed code is placed in the lower or the upper half of the physical word, and that choice flips on every compressed write to the address, which spreads wear across both halves. Five metadata bits per word record the format, the half in use and the code length. They go through the same differential mask as the data.

Read requests go through the same read port. The unit uses the metadata to find the code, maps the code back to its dictionary value and returns the original 32-bit word. For each write the unit also reports how many cells it programmed.

Top module: `nvm_cwrite_unit`

## Requirements
- R1: A write whose data equals dictionary entry i is stored compressed. Metadata bit 0 is 1 (compressed) and metadata bits [4:2] hold the code length: i+1 for i below 7, and 7 for i = 7. The 16-bit payload holds the code right-aligned with zeros above it, as value 1 for i below 7 and value 0 for i = 7.
- R2: A write that matches no dictionary entry is stored raw. All 32 bits hold the data, metadata bit 0 is 0, bits [4:2] are 0, and metadata bit 1 (placement) keeps its old value.
- R3: The write masks equal old XOR new, for the data bits and for the metadata bits. Rewriting an unchanged value programs no cell.
- R4: Each compressed write inverts the address's placement bit (metadata bit 1). The payload occupies data bits [15:0] when the new bit is 0 and bits [31:16] when it is 1.
- R5: On a compressed write, the half of the word outside the payload is neither masked nor changed. Its old contents survive.
- R6: During the write cycle, bitCount equals the number of set bits in the data mask plus the number of set bits in the metadata mask.
- R7: A write is accepted while reqReady is high. The next cycle is the read cycle, with memRdEn high. The cycle after that is the masked write, with memWrEn high. reqReady stays low from the read cycle until after the write cycle.
- R8: A read is accepted, its read cycle follows, and in the next cycle rspValid is high and rspData returns the original word, whether it was stored raw or compressed in either half.
- R9: Dictionary entries load through cfgWe/cfgIdx/cfgVal. When several entries hold the same value, the lowest index is used for encoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Dictionary entry load strobe |
| cfgIdx | input | 3 | Dictionary entry index |
| cfgVal | input | 32 | Dictionary entry value |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address |
| reqData | input | 32 | Write data |
| reqReady | output | 1 | Unit idle, request accepted when valid |
| rspValid | output | 1 | Read data valid |
| rspData | output | 32 | Decoded read data |
| memRdEn | output | 1 | Array read strobe (data returns next cycle) |
| memAddr | output | ADDR_W | Array address |
| memRdData | input | 32 | Stored data word |
| memRdMeta | input | 5 | Stored metadata {len[2:0], placement, compressed} |
| memWrEn | output | 1 | Masked array write strobe |
| memWrData | output | 32 | New data image |
| memWrMask | output | 32 | Per-bit program enables for data |
| memMetaData | output | 5 | New metadata |
| memMetaMask | output | 5 | Per-bit program enables for metadata |
| bitCount | output | 6 | Cells programmed by the current write |

## Verification
The bench targets the case where the last two dictionary entries share a code length and differ only in payload bit 0. A design that decodes from the length alone would return entry 6 in place of entry 7. It walks one address through raw, compressed, compressed and raw writes. A design that fails to flip placement, clears the idle half, or changes placement on a raw write would leave a wrong stored image or metadata mask. It also rewrites identical values, where any nonzero mask or count means wasted programming. Finally, it loads a duplicate dictionary value, where a design that picks a higher index would emit a longer code.

// File: rtl/nvmc_pkg.sv
package nvmc_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = WORD_W / 2;
  localparam int LEN_W  = 3;
  localparam int META_W = LEN_W + 2;
  localparam int DICT_N = 8;
  localparam int IDX_W  = $clog2(DICT_N);
  localparam int CNT_W  = $clog2(WORD_W + META_W + 1);

  typedef struct packed {
    logic [LEN_W-1:0] codeLen;
    logic             upper;
    logic             comp;
  } meta_t;

  typedef struct packed {
    logic capture;
    logic rdEn;
    logic wrEn;
    logic rspEn;
  } strobe_t;
endpackage

// File: rtl/nvmc_ctrl.sv
module nvmc_ctrl
  import nvmc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output strobe_t stb
);
  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE, S_RESP} state_e;
  state_e state;
  logic   opWrite;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      opWrite <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (reqValid) begin
          state   <= S_READ;
          opWrite <= reqWrite;
        end
        S_READ:  state <= opWrite ? S_WRITE : S_RESP;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign reqReady    = (state == S_IDLE);
  assign stb.capture = (state == S_IDLE) && reqValid;
  assign stb.rdEn    = (state == S_READ);
  assign stb.wrEn    = (state == S_WRITE);
  assign stb.rspEn   = (state == S_RESP);

  // R7: read cycle directly follows acceptance
  p_read_after_accept_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> stb.rdEn);
  // R7: a write request reaches the masked write two cycles after acceptance
  p_write_after_read_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqWrite) |=> ##1 stb.wrEn);
  // R7: unit is idle again after the masked write
  p_ready_after_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrEn |=> reqReady);
endmodule

// File: rtl/nvmc_dpath.sv
module nvmc_dpath
  import nvmc_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              cfgWe,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [WORD_W-1:0] cfgVal,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [WORD_W-1:0] reqData,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [WORD_W-1:0] memRdData,
  input  logic [META_W-1:0] memRdMeta,
  output logic [WORD_W-1:0] memWrData,
  output logic [WORD_W-1:0] memWrMask,
  output logic [META_W-1:0] memMetaData,
  output logic [META_W-1:0] memMetaMask,
  output logic [CNT_W-1:0]  bitCount,
  output logic [WORD_W-1:0] rspData
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DICT_N - 1);
  localparam logic [LEN_W-1:0] MAX_LEN  = LEN_W'(DICT_N - 1);

  logic [WORD_W-1:0] dict [DICT_N];
  logic [ADDR_W-1:0] addrQ;
  logic [WORD_W-1:0] dataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DICT_N; i++) dict[i] <= '0;
    end else if (cfgWe) begin
      dict[cfgIdx] <= cfgVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
    end else if (stb.capture) begin
      addrQ <= reqAddr;
      dataQ <= reqData;
    end
  end

  assign memAddr = addrQ;

  // dictionary match, one comparator per entry
  logic [DICT_N-1:0] hitVec;
  for (genvar g = 0; g < DICT_N; g++) begin : g_match
    assign hitVec[g] = (dict[g] == dataQ);
  end

  logic             hit;
  logic [IDX_W-1:0] hitIdx;
  always_comb begin
    hit    = 1'b0;
    hitIdx = '0;
    for (int i = DICT_N - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        hit    = 1'b1;
        hitIdx = IDX_W'(i);
      end
    end
  end

  // new image and metadata
  meta_t             oldMeta, newMeta;
  logic [HALF_W-1:0] payload;
  logic [WORD_W-1:0] newImg;

  assign oldMeta = meta_t'(memRdMeta);

  always_comb begin
    payload = (hitIdx == LAST_IDX) ? '0 : HALF_W'(1);
    newMeta = oldMeta;
    newImg  = dataQ;
    if (hit) begin
      newMeta.comp    = 1'b1;
      newMeta.upper   = ~oldMeta.upper;
      newMeta.codeLen = (hitIdx == LAST_IDX) ? MAX_LEN : LEN_W'(hitIdx) + LEN_W'(1);
      newImg = newMeta.upper ? {payload, memRdData[HALF_W-1:0]}
                             : {memRdData[WORD_W-1:HALF_W], payload};
    end else begin
      newMeta.comp    = 1'b0;
      newMeta.codeLen = '0;
    end
  end

  assign memWrData   = newImg;
  assign memMetaData = newMeta;
  assign memWrMask   = newImg ^ memRdData;
  assign memMetaMask = newMeta ^ oldMeta;

  always_comb begin
    bitCount = '0;
    for (int i = 0; i < WORD_W; i++) bitCount = bitCount + CNT_W'(memWrMask[i]);
    for (int i = 0; i < META_W; i++) bitCount = bitCount + CNT_W'(memMetaMask[i]);
  end

  // read decode: length picks the entry, payload bit 0 splits the two longest codes
  logic [HALF_W-1:0] rdPayload;
  logic [IDX_W-1:0]  decIdx;
  always_comb begin
    rdPayload = oldMeta.upper ? memRdData[WORD_W-1:HALF_W] : memRdData[HALF_W-1:0];
    if (oldMeta.codeLen == MAX_LEN)
      decIdx = rdPayload[0] ? LAST_IDX - IDX_W'(1) : LAST_IDX;
    else
      decIdx = IDX_W'(oldMeta.codeLen - LEN_W'(1));
    rspData = oldMeta.comp ? dict[decIdx] : memRdData;
  end

  // R4: compressed writes flip placement
  p_place_flip_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrEn && memMetaData[0]) |-> (memMetaData[1] != memRdMeta[1]));
  // R5: idle half of a compressed word carries no program enables
  p_idle_half_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrEn && memMetaData[0]) |->
      (memMetaData[1] ? (memWrMask[HALF_W-1:0] == '0) : (memWrMask[WORD_W-1:HALF_W] == '0)));
  // R2: raw writes store the request word and keep placement
  p_raw_store_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrEn && !memMetaData[0]) |->
      (memWrData == dataQ && memMetaData[4:2] == '0 && memMetaData[1] == memRdMeta[1]));
  // R1: a compressed code never has length zero
  p_len_nonzero_r1: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrEn && memMetaData[0]) |-> (memMetaData[4:2] != '0));
endmodule

// File: rtl/nvm_cwrite_unit.sv
module nvm_cwrite_unit
  import nvmc_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [WORD_W-1:0] cfgVal,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [WORD_W-1:0] reqData,
  output logic              reqReady,
  output logic              rspValid,
  output logic [WORD_W-1:0] rspData,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [WORD_W-1:0] memRdData,
  input  logic [META_W-1:0] memRdMeta,
  output logic              memWrEn,
  output logic [WORD_W-1:0] memWrData,
  output logic [WORD_W-1:0] memWrMask,
  output logic [META_W-1:0] memMetaData,
  output logic [META_W-1:0] memMetaMask,
  output logic [CNT_W-1:0]  bitCount
);
  strobe_t stb;

  nvmc_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqReady (reqReady),
    .stb      (stb)
  );

  nvmc_dpath #(.ADDR_W(ADDR_W)) uDpath (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .cfgWe       (cfgWe),
    .cfgIdx      (cfgIdx),
    .cfgVal      (cfgVal),
    .reqAddr     (reqAddr),
    .reqData     (reqData),
    .memAddr     (memAddr),
    .memRdData   (memRdData),
    .memRdMeta   (memRdMeta),
    .memWrData   (memWrData),
    .memWrMask   (memWrMask),
    .memMetaData (memMetaData),
    .memMetaMask (memMetaMask),
    .bitCount    (bitCount),
    .rspData     (rspData)
  );

  assign memRdEn  = stb.rdEn;
  assign memWrEn  = stb.wrEn;
  assign rspValid = stb.rspEn;
endmodule

// File: tb/tb_nvm_cwrite_unit.sv
`timescale 1ns/1ps
module tb_nvm_cwrite_unit;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgIdx = '0;
  logic [31:0] cfgVal = '0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [31:0] reqData = '0;
  logic        reqReady, rspValid, memRdEn, memWrEn;
  logic [31:0] rspData, memWrData, memWrMask;
  logic [AW-1:0] memAddr;
  logic [31:0] memRdData;
  logic [4:0]  memRdMeta, memMetaData, memMetaMask;
  logic [5:0]  bitCount;

  int nChecks = 0;
  int nErr = 0;

  always #2.5 clk = ~clk;

  nvm_cwrite_unit #(.ADDR_W(AW)) dut (.*);

  // array model: registered read, masked write
  logic [31:0] arrD [DEPTH];
  logic [4:0]  arrM [DEPTH];
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin arrD[i] <= '0; arrM[i] <= '0; end
      memRdData <= '0;
      memRdMeta <= '0;
    end else begin
      if (memRdEn) begin
        memRdData <= arrD[memAddr];
        memRdMeta <= arrM[memAddr];
      end
      if (memWrEn) begin
        arrD[memAddr] <= (arrD[memAddr] & ~memWrMask) | (memWrData & memWrMask);
        arrM[memAddr] <= (arrM[memAddr] & ~memMetaMask) | (memMetaData & memMetaMask);
      end
    end
  end

  logic [31:0] tbDict [8];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected image per requirements R1, R2, R4, R5, R9
  task automatic model(input logic [31:0] oldD, input logic [4:0] oldM, input logic [31:0] d,
                       output logic [31:0] nD, output logic [4:0] nM);
    int idx = -1;
    logic up;
    logic [15:0] pay;
    for (int i = 7; i >= 0; i--) if (tbDict[i] == d) idx = i;
    if (idx < 0) begin
      nD = d;
      nM = {3'd0, oldM[1], 1'b0};
    end else begin
      up  = ~oldM[1];
      pay = (idx == 7) ? 16'd0 : 16'd1;
      nD  = up ? {pay, oldD[15:0]} : {oldD[31:16], pay};
      nM  = {(idx == 7) ? 3'd7 : 3'(idx + 1), up, 1'b1};
    end
  endtask

  task automatic loadDict(input int idx, input logic [31:0] v);
    @(negedge clk);
    cfgWe = 1'b1; cfgIdx = 3'(idx); cfgVal = v;
    @(negedge clk);
    cfgWe = 1'b0;
    tbDict[idx] = v;
  endtask

  task automatic doWrite(input logic [AW-1:0] a, input logic [31:0] d);
    logic [31:0] oD, nD;
    logic [4:0] oM, nM;
    @(negedge clk);
    oD = arrD[a]; oM = arrM[a];
    model(oD, oM, d, nD, nM);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqData = d;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R7 read cycle rdEn", 64'(memRdEn), 64'd1);
    chk("R7 ready low in read", 64'(reqReady), 64'd0);
    @(negedge clk);
    chk("R7 write cycle wrEn", 64'(memWrEn), 64'd1);
    chk("R7 ready low in write", 64'(reqReady), 64'd0);
    chk("R3 data mask", 64'(memWrMask), 64'(oD ^ nD));
    chk("R3 meta mask", 64'(memMetaMask), 64'(oM ^ nM));
    chk("R1 R2 R4 metadata", 64'(memMetaData), 64'(nM));
    chk("R6 bit count", 64'(bitCount), 64'($countones(oD ^ nD) + $countones(oM ^ nM)));
    @(negedge clk);
    chk("R7 ready back", 64'(reqReady), 64'd1);
    chk("R5 stored image", 64'(arrD[a]), 64'(nD));
    chk("R4 stored metadata", 64'(arrM[a]), 64'(nM));
  endtask

  task automatic doRead(input logic [AW-1:0] a, input logic [31:0] expD);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R8 read cycle rdEn", 64'(memRdEn), 64'd1);
    @(negedge clk);
    chk("R8 rspValid", 64'(rspValid), 64'd1);
    chk("R8 rspData", 64'(rspData), 64'(expD));
    chk("R8 no write on read", 64'(memWrEn), 64'd0);
  endtask

  task automatic t_reset();
    chk("R7 reset ready", 64'(reqReady), 64'd1);
    chk("R7 reset no write", 64'(memWrEn), 64'd0);
    chk("R8 reset no resp", 64'(rspValid), 64'd0);
  endtask

  task automatic t_placement();
    // R2 raw, R4 flip to upper, flip to lower, R2 raw keeps placement
    doWrite(6'd3, 32'hA5A5_3C3C);
    chk("R2 raw format bit", 64'(arrM[3][0]), 64'd0);
    doWrite(6'd3, tbDict[2]);
    chk("R4 first compressed goes upper", 64'(arrM[3][1]), 64'd1);
    chk("R5 lower half kept", 64'(arrD[3][15:0]), 64'h3C3C);
    doRead(6'd3, tbDict[2]);
    doWrite(6'd3, tbDict[4]);
    chk("R4 second compressed goes lower", 64'(arrM[3][1]), 64'd0);
    chk("R5 upper half kept", 64'(arrD[3][31:16]), 64'h0001);
    doRead(6'd3, tbDict[4]);
    doWrite(6'd3, 32'h0F0F_F0F0);
    chk("R2 raw keeps placement", 64'(arrM[3][1]), 64'd0);
    doRead(6'd3, 32'h0F0F_F0F0);
  endtask

  task automatic t_codeTable();
    for (int i = 0; i < 8; i++) begin
      doWrite(6'(20 + i), tbDict[i]);
      chk("R1 code length field", 64'(arrM[20 + i][4:2]), 64'((i == 7) ? 7 : i + 1));
      doRead(6'(20 + i), tbDict[i]);
    end
    // R1: entries 6 and 7 share length 7, payload bit 0 separates them
    doRead(6'd26, tbDict[6]);
    doRead(6'd27, tbDict[7]);
  endtask

  task automatic t_sameValue();
    doWrite(6'd40, 32'h1357_9BDF);
    doWrite(6'd40, 32'h1357_9BDF);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 6'd40; reqData = 32'h1357_9BDF;
    @(negedge clk); reqValid = 1'b0;
    @(negedge clk);
    chk("R3 unchanged rewrite mask", 64'(memWrMask), 64'd0);
    chk("R6 unchanged rewrite count", 64'(bitCount), 64'd0);
    @(negedge clk);
  endtask

  task automatic t_duplicate();
    logic [31:0] keep5;
    keep5 = tbDict[5];
    loadDict(5, tbDict[2]);
    doWrite(6'd50, tbDict[2]);
    chk("R9 lowest index wins", 64'(arrM[50][4:2]), 64'd3);
    doRead(6'd50, tbDict[2]);
    loadDict(5, keep5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    loadDict(0, 32'h0000_0000);
    loadDict(1, 32'hFFFF_FFFF);
    loadDict(2, 32'hDEAD_BEEF);
    loadDict(3, 32'h0000_0001);
    loadDict(4, 32'h8000_0000);
    loadDict(5, 32'h1234_5678);
    loadDict(6, 32'hCAFE_F00D);
    loadDict(7, 32'h55AA_55AA);
    t_placement();
    t_codeTable();
    t_sameValue();
    t_duplicate();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nErr++;
    nChecks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule